// File: doc/BRIEF.md
# Ring Index Tracker with Wrap Flag

This block keeps the producer and consumer positions of a circular buffer that lives in memory. The buffer holds a power-of-two number of fixed-size slots, and the size is chosen at run time as a base-two exponent. Each position register carries the slot index in its low bits and a wrap flag one bit above it. The flag lets the block tell a completely full buffer from an empty one without giving up a slot.

The surrounding logic pulses one strobe when it has written a slot and another when it has read one. The block returns the full and empty status, the raw 32-bit position registers, and the byte address of the slot that each side would touch next. The consumer register also holds a 7-bit error code in its upper bits. Consumer advances never alter that code. A single write strobe loads it.

Top module: `ring_tracker`

## Requirements
- R1: While reset is high, and on the first cycle after it, both position registers read zero, empty is 1, full is 0, the error pulse is 0, and both slot addresses equal the masked base.
- R2: An accepted producer advance adds one to the producer register over bits [L:0] only, where L is the effective size exponent. The wrap flag at bit L toggles when the index rolls over, and bits above L stay zero.
- R3: An accepted consumer advance replaces only bits [L:0] of the consumer register with their incremented value. The error code at bits [30:24] and all other upper bits keep their values.
- R4: Empty is 1 exactly when the two registers agree over bits [L:0].
- R5: Full is 1 exactly when the two registers XOR-ed over bits [L:0] give the value 2^L, that is, equal indices with different wrap flags. Full and empty are never 1 together.
- R6: Each slot address is (base AND 0x000F_FFFF_FFFF_FFC0) plus the slot size in bytes times bits [L-1:0] of the corresponding register.
- R7: A producer advance while full, or a consumer advance while empty, leaves the register unchanged. In that case the error pulse output is 1 for the following cycle only.
- R8: Size exponents above 19 act as 19. A change of the input that does not change the effective exponent has no effect.
- R9: When the effective exponent changes, bits [19:0] of both registers clear on that edge and the consumer error code is kept. Advances requested in that cycle are dropped, and no error pulse is raised.
- R10: A pulse on the error write strobe loads the 7-bit code into bits [30:24] of the consumer register.
- R11: When both advances arrive in the same cycle, each is judged against the status held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| size_exp_i | input | 5 | Size exponent L; ring holds 2^L slots |
| base_i | input | 64 | Ring base byte address (masked inside) |
| slot_bytes_i | input | 8 | Slot size in bytes |
| prod_adv_i | input | 1 | Producer advance strobe |
| cons_adv_i | input | 1 | Consumer advance strobe |
| err_we_i | input | 1 | Load error code into consumer register |
| err_code_i | input | 7 | Error code value |
| full_o | output | 1 | Ring full |
| empty_o | output | 1 | Ring empty |
| prod_addr_o | output | 64 | Byte address of the next producer slot |
| cons_addr_o | output | 64 | Byte address of the next consumer slot |
| prod_reg_o | output | 32 | Raw producer register |
| cons_reg_o | output | 32 | Raw consumer register including error code |
| adv_err_o | output | 1 | One-cycle pulse after a rejected advance |

## Verification
The ring is filled to full and drained to empty at a four-slot size, then filled again, so that full is seen with the wrap flags in both orders. This separates the wrap-flag comparison from a plain index comparison. A nonzero error code is loaded before draining, which shows that consumer advances leave the upper bits alone. Coincident advances on an empty ring, resizes that do and do not change the clamped exponent, and a one-slot ring check how advances are judged against the prior status and how the index mask behaves at its edges. Two slot sizes check the address multiply.

// File: rtl/ring_pkg.sv
package ring_pkg;
    localparam int MAX_EXP  = 19;
    localparam int EXP_W    = 5;
    localparam int PTR_W    = 32;
    localparam int ADDR_W   = 64;
    localparam int SLOT_W   = 8;
    localparam int CODE_LSB = 24;
    localparam int CODE_W   = 7;
    localparam logic [ADDR_W-1:0] BASE_KEEP = 64'h000F_FFFF_FFFF_FFC0;

    typedef enum logic [1:0] {
        PTR_HOLD  = 2'd0,
        PTR_STEP  = 2'd1,
        PTR_CLEAR = 2'd2
    } ptr_op_e;

    typedef struct packed {
        logic full;
        logic empty;
    } ring_stat_t;

    function automatic logic [EXP_W-1:0] clamp_exp(logic [EXP_W-1:0] e);
        return (int'(e) > MAX_EXP) ? EXP_W'(MAX_EXP) : e;
    endfunction

    function automatic logic [PTR_W-1:0] wrap_bit(logic [EXP_W-1:0] e);
        return PTR_W'(1) << e;
    endfunction

    function automatic logic [PTR_W-1:0] idx_mask(logic [EXP_W-1:0] e);
        return wrap_bit(e) - PTR_W'(1);
    endfunction

    function automatic logic [PTR_W-1:0] span_mask(logic [EXP_W-1:0] e);
        return (wrap_bit(e) << 1) - PTR_W'(1);
    endfunction
endpackage

// File: rtl/ring_ptr.sv
module ring_ptr
    import ring_pkg::*;
#(
    parameter bit KEEP_UPPER = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [EXP_W-1:0]  size_exp,
    input  ptr_op_e           op,
    input  logic              code_we,
    input  logic [CODE_W-1:0] code,
    output logic [PTR_W-1:0]  q
);
    localparam logic [PTR_W-1:0] CLR_SPAN = (PTR_W'(1) << (MAX_EXP + 1)) - PTR_W'(1);

    logic [PTR_W-1:0] stepped;
    logic [PTR_W-1:0] nxt;

    generate
        if (KEEP_UPPER) begin : g_keep
            always_comb begin
                stepped = (q & ~span_mask(size_exp)) | ((q + PTR_W'(1)) & span_mask(size_exp));
                nxt     = q;
                case (op)
                    PTR_STEP:  nxt = stepped;
                    PTR_CLEAR: nxt = q & ~CLR_SPAN;
                    default:   nxt = q;
                endcase
                if (code_we) nxt[CODE_LSB +: CODE_W] = code;
            end

            // R3: advances never disturb the error code
            a_r3_code_kept: assert property (@(posedge clk) disable iff (rst)
                (op == PTR_STEP && !code_we) |=> (q[CODE_LSB +: CODE_W] == $past(q[CODE_LSB +: CODE_W])));
            // R10: a code write lands in the upper field
            a_r10_code_load: assert property (@(posedge clk) disable iff (rst)
                code_we |=> (q[CODE_LSB +: CODE_W] == $past(code)));
        end else begin : g_plain
            logic unused_code;
            assign unused_code = code_we ^ (^code);
            always_comb begin
                stepped = (q + PTR_W'(1)) & span_mask(size_exp);
                case (op)
                    PTR_STEP:  nxt = stepped;
                    PTR_CLEAR: nxt = '0;
                    default:   nxt = q;
                endcase
            end

            // R2: nothing above the wrap flag is ever set
            a_r2_no_upper: assert property (@(posedge clk) disable iff (rst)
                (q & ~span_mask(size_exp)) == '0);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/ring_status.sv
module ring_status
    import ring_pkg::*;
(
    input  logic [EXP_W-1:0] size_exp,
    input  logic [PTR_W-1:0] prod,
    input  logic [PTR_W-1:0] cons,
    output ring_stat_t       stat
);
    logic [PTR_W-1:0] diff;

    always_comb begin
        diff       = (prod ^ cons) & span_mask(size_exp);
        stat.empty = (diff == '0);
        stat.full  = (diff == wrap_bit(size_exp));
    end
endmodule

// File: rtl/ring_addr.sv
module ring_addr
    import ring_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [SLOT_W-1:0] slot_bytes,
    input  logic [EXP_W-1:0]  size_exp,
    input  logic [PTR_W-1:0]  ptr,
    output logic [ADDR_W-1:0] addr
);
    logic [PTR_W-1:0] idx;

    always_comb begin
        idx  = ptr & idx_mask(size_exp);
        addr = (base & BASE_KEEP) + (ADDR_W'(slot_bytes) * ADDR_W'(idx));
    end
endmodule

// File: rtl/ring_tracker.sv
module ring_tracker
    import ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [EXP_W-1:0]  size_exp_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [SLOT_W-1:0] slot_bytes_i,
    input  logic              prod_adv_i,
    input  logic              cons_adv_i,
    input  logic              err_we_i,
    input  logic [CODE_W-1:0] err_code_i,
    output logic              full_o,
    output logic              empty_o,
    output logic [ADDR_W-1:0] prod_addr_o,
    output logic [ADDR_W-1:0] cons_addr_o,
    output logic [PTR_W-1:0]  prod_reg_o,
    output logic [PTR_W-1:0]  cons_reg_o,
    output logic              adv_err_o
);
    logic [EXP_W-1:0] exp_eff;
    logic [EXP_W-1:0] exp_q;
    logic             resize;
    ring_stat_t       stat;
    ptr_op_e          prod_op;
    ptr_op_e          cons_op;
    logic             reject;
    logic             err_q;

    assign exp_eff = clamp_exp(size_exp_i);
    assign resize  = (exp_eff != exp_q);

    always_comb begin
        reject  = !resize && ((prod_adv_i && stat.full) || (cons_adv_i && stat.empty));
        prod_op = PTR_HOLD;
        cons_op = PTR_HOLD;
        if (resize) begin
            prod_op = PTR_CLEAR;
            cons_op = PTR_CLEAR;
        end else begin
            if (prod_adv_i && !stat.full)  prod_op = PTR_STEP;
            if (cons_adv_i && !stat.empty) cons_op = PTR_STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q <= exp_eff;
            err_q <= 1'b0;
        end else begin
            exp_q <= exp_eff;
            err_q <= reject;
        end
    end

    ring_ptr #(.KEEP_UPPER(1'b0)) u_prod (
        .clk(clk), .rst(rst), .size_exp(exp_q), .op(prod_op),
        .code_we(1'b0), .code('0), .q(prod_reg_o)
    );

    ring_ptr #(.KEEP_UPPER(1'b1)) u_cons (
        .clk(clk), .rst(rst), .size_exp(exp_q), .op(cons_op),
        .code_we(err_we_i), .code(err_code_i), .q(cons_reg_o)
    );

    ring_status u_stat (
        .size_exp(exp_q), .prod(prod_reg_o), .cons(cons_reg_o), .stat(stat)
    );

    ring_addr u_paddr (
        .base(base_i), .slot_bytes(slot_bytes_i), .size_exp(exp_q),
        .ptr(prod_reg_o), .addr(prod_addr_o)
    );

    ring_addr u_caddr (
        .base(base_i), .slot_bytes(slot_bytes_i), .size_exp(exp_q),
        .ptr(cons_reg_o), .addr(cons_addr_o)
    );

    assign full_o    = stat.full;
    assign empty_o   = stat.empty;
    assign adv_err_o = err_q;

    // R5: status flags are exclusive
    a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(full_o && empty_o));
    // R7: producer held when full
    a_r7_prod_hold: assert property (@(posedge clk) disable iff (rst)
        (prod_adv_i && full_o && !resize) |=> $stable(prod_reg_o));
    // R7: consumer advance on empty raises the pulse
    a_r7_err_pulse: assert property (@(posedge clk) disable iff (rst)
        (cons_adv_i && empty_o && !resize) |=> adv_err_o);
    // R9: resize clears the producer and raises no pulse
    a_r9_resize_clear: assert property (@(posedge clk) disable iff (rst)
        resize |=> (prod_reg_o == '0 && !adv_err_o));
endmodule

// File: tb/ring_tracker_tb.sv
module ring_tracker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  size_exp = 5'd2;
    logic [63:0] base = 64'hFFF1_2345_6789_ABFF;
    logic [7:0]  slot_bytes = 8'd16;
    logic        prod_adv = 1'b0;
    logic        cons_adv = 1'b0;
    logic        err_we = 1'b0;
    logic [6:0]  err_code = '0;
    logic        full, empty, adv_err;
    logic [63:0] prod_addr, cons_addr;
    logic [31:0] prod_reg, cons_reg;

    localparam logic [63:0] BM = 64'h0001_2345_6789_ABC0;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    ring_tracker u_dut (
        .clk(clk), .rst(rst), .size_exp_i(size_exp), .base_i(base),
        .slot_bytes_i(slot_bytes), .prod_adv_i(prod_adv), .cons_adv_i(cons_adv),
        .err_we_i(err_we), .err_code_i(err_code), .full_o(full), .empty_o(empty),
        .prod_addr_o(prod_addr), .cons_addr_o(cons_addr), .prod_reg_o(prod_reg),
        .cons_reg_o(cons_reg), .adv_err_o(adv_err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic adv(input logic p, input logic c);
        prod_adv = p;
        cons_adv = c;
        step();
        prod_adv = 1'b0;
        cons_adv = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 prod", prod_reg, 0);
        check("R1 cons", cons_reg, 0);
        check("R1 empty", empty, 1);
        check("R1 full", full, 0);
        check("R1 err", adv_err, 0);
        check("R1 addr", prod_addr, BM);
    endtask

    task automatic t_fill();
        adv(1, 0);
        check("R2 one", prod_reg, 1);
        check("R6 paddr", prod_addr, BM + 16);
        check("R4 not empty", empty, 0);
        for (int i = 0; i < 3; i++) adv(1, 0);
        check("R2 wrap set", prod_reg, 4);
        check("R5 full", full, 1);
        check("R6 paddr wrap", prod_addr, BM);
        adv(1, 0);
        check("R7 prod held", prod_reg, 4);
        check("R7 pulse", adv_err, 1);
        step();
        check("R7 pulse ends", adv_err, 0);
    endtask

    task automatic t_drain();
        err_we = 1'b1;
        err_code = 7'h55;
        step();
        err_we = 1'b0;
        check("R10 code", cons_reg, 32'h5500_0000);
        adv(0, 1);
        check("R6 caddr", cons_addr, BM + 16);
        for (int i = 0; i < 3; i++) adv(0, 1);
        check("R3 cons", cons_reg, 32'h5500_0004);
        check("R4 empty", empty, 1);
        check("R5 not full", full, 0);
        adv(0, 1);
        check("R7 cons held", cons_reg, 32'h5500_0004);
        check("R7 cons pulse", adv_err, 1);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 4; i++) adv(1, 0);
        check("R2 wrap clear", prod_reg, 0);
        check("R5 full other", full, 1);
        for (int i = 0; i < 4; i++) adv(0, 1);
        check("R3 cons wrap", cons_reg, 32'h5500_0000);
        check("R4 empty again", empty, 1);
    endtask

    task automatic t_both();
        adv(1, 1);
        check("R11 prod", prod_reg, 1);
        check("R11 cons", cons_reg, 32'h5500_0000);
        check("R11 pulse", adv_err, 1);
        adv(1, 1);
        check("R11 prod2", prod_reg, 2);
        check("R11 cons2", cons_reg, 32'h5500_0001);
        check("R11 nopulse", adv_err, 0);
        slot_bytes = 8'd32;
        #1;
        check("R6 caddr32", cons_addr, BM + 32);
        check("R6 paddr32", prod_addr, BM + 64);
    endtask

    task automatic t_resize();
        size_exp = 5'd25;
        adv(1, 0);
        check("R9 prod clr", prod_reg, 0);
        check("R9 cons kept", cons_reg, 32'h5500_0000);
        check("R9 nopulse", adv_err, 0);
        adv(1, 0);
        adv(1, 0);
        check("R8 big ring", full, 0);
        size_exp = 5'd19;
        step();
        check("R8 clamp", prod_reg, 2);
        size_exp = 5'd0;
        step();
        check("R9 clr0", prod_reg, 0);
        adv(1, 0);
        check("R5 one slot", full, 1);
        adv(0, 1);
        check("R3 one slot", cons_reg, 32'h5500_0001);
        adv(1, 0);
        check("R2 one slot", prod_reg, 0);
        check("R5 one slot2", full, 1);
        adv(1, 0);
        check("R7 one slot", adv_err, 1);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst = 1'b0;
                t_reset();
                t_fill();
                t_drain();
                t_wrap();
                t_both();
                t_resize();
            end
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=hang expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule